// File: doc/BRIEF.md
# Clock Output Select and Divide

This block drives a single debug clock pin with one of sixteen internal clock sources. Software writes a packed control word through a simple register port in the system clock domain. The word holds an output enable, a logarithmic divide code and a four-bit source number. The chosen source passes through a power-of-two divider, from 1 to 16, before it reaches the pin. A pad output enable tells the I/O cell when to drive.

Each source has its own lane. A lane runs a synchronous counter on its own clock, and only the lane that is selected and enabled may run. A change of source, divide code or enable is never applied in place. The control sequencer first asks the running lane to stop. The lane stops only at the end of a complete high phase. The sequencer waits until that stop is confirmed across the clock crossing, then loads the new setting and starts the new lane. The new output therefore begins with a full low phase.

Top module: `ckout_unit`

## Requirements
- R1: While reset is held and right after it is released, the register reads 0, `pad_oe` is 0 and `clk_out` is 0.
- R2: The register holds the enable in bit 9, the divide code in bits 8:6 and the source number in bits 3:0. All other bits, including 5:4, read as 0 and ignore writes, so writing 0xFFFFFFFF reads back 0x3CF.
- R3: Source number n (0 to 15) routes `src_clk[n]` to `clk_out`. Writing 0x208 selects source 8 undivided.
- R4: Divide codes 0 to 4 give an output period of the source period times 1, 2, 4, 8 and 16. Writing 0x300 gives source 0 divided by 16.
- R5: Divide codes 5, 6 and 7 divide by 16 and are read back exactly as written.
- R6: For codes 1 and up, the output high time is exactly half the output period. For code 0, the output copies the source waveform.
- R7: While the enable bit is 0, `pad_oe` is 0 and `clk_out` stays low with no edges, whatever the other fields hold.
- R8: Any output high pulse lasts exactly half the output period of either the old or the new setting. Any low pulse lasts at least the shorter of those two half periods.
- R9: After the enable is cleared, the current high phase completes before the output stops. `pad_oe` stays 1 until the output has stopped, and `clk_out` never rises while `pad_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for the register port and the sequencer |
| sys_rst_n | input | 1 | Asynchronous active-low reset, released synchronously in every domain |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | DATA_W | Register write data |
| cfg_rdata | output | DATA_W | Register read data |
| src_clk | input | NUM_SRC | Free-running source clocks, one per lane |
| clk_out | output | 1 | Selected and divided clock |
| pad_oe | output | 1 | Pad drive enable |

## Verification
A lane counter that wraps at the wrong point shows at the pin within one output period, as a wrong period or an unequal high time. A lane that stops at the wrong point, or a sequencer that starts the new lane before the old one is confirmed idle, leaves a truncated high pulse or a short low gap. The per-pulse monitor catches this at the first switch where it happens. A stuck or wrongly decoded register field shows in the readback on the next read, or in the output within a few microseconds of the write. Sweeping every source against every divide code means each lane's counter and each select decode is checked on its own.

// File: rtl/ckout_pkg.sv
`timescale 1ns/1ps
package ckout_pkg;
  // Field positions within the control word; software depends on them
  localparam int unsigned EN_BIT  = 9;
  localparam int unsigned DIV_LSB = 6;
  localparam int unsigned DIV_W   = 3;
  localparam int unsigned SEL_LSB = 0;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,  // settings applied, nothing pending
    ST_WAKE  = 2'd1,  // new lane requested, waiting for it to run
    ST_DRAIN = 2'd2   // running lane asked to stop, waiting for idle
  } seq_state_e;
endpackage

// File: rtl/ckout_rst_sync.sv
`timescale 1ns/1ps
module ckout_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n = out_q;
endmodule

// File: rtl/ckout_lane.sv
`timescale 1ns/1ps
module ckout_lane #(
  parameter int unsigned LOG2_MAX = 4,
  localparam int unsigned CNT_W = LOG2_MAX,
  localparam int unsigned SH_W  = $clog2(LOG2_MAX + 1)
) (
  input  logic            src_clk,
  input  logic            arst_n,
  input  logic            req,       // from sys domain, registered there
  input  logic [SH_W-1:0] shift,     // quasi-static: changes only while idle
  output logic            lane_clk,
  output logic            busy
);
  logic             rst_n;
  logic             req_s1_q, req_s2_q;
  logic             run_q, run_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             q_q, q_n;
  logic             busy_q;
  logic             pass_q;            // negedge gate for the undivided path
  logic [CNT_W-1:0] mask;
  logic             div1;

  ckout_rst_sync u_rst (.clk(src_clk), .arst_n(arst_n), .rst_n(rst_n));

  always_comb begin
    mask = '0;
    for (int b = 0; b < int'(CNT_W); b++) begin
      if (b < int'(shift)) mask[b] = 1'b1;
    end
  end

  assign div1 = (shift == '0);

  always_comb begin
    run_n = run_q;
    cnt_n = cnt_q;
    if (!run_q) begin
      cnt_n = '0;
      if (req_s2_q) run_n = 1'b1;
    end else begin
      cnt_n = (cnt_q + 1'b1) & mask;
      // stop only at the wrap, i.e. at the end of a high phase
      if (((cnt_q & mask) == mask) && !req_s2_q) run_n = 1'b0;
    end
    q_n = 1'b0;
    for (int b = 0; b < int'(CNT_W); b++) begin
      if (int'(shift) == b + 1) q_n = run_n & cnt_n[b];
    end
  end

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) begin
      req_s1_q <= 1'b0;
      req_s2_q <= 1'b0;
      run_q    <= 1'b0;
      cnt_q    <= '0;
      q_q      <= 1'b0;
      busy_q   <= 1'b0;
    end else begin
      req_s1_q <= req;
      req_s2_q <= req_s1_q;
      run_q    <= run_n;
      cnt_q    <= cnt_n;
      q_q      <= q_n;
      busy_q   <= run_q;   // one cycle late: the negedge gate has closed by then
    end
  end

  always_ff @(negedge src_clk or negedge rst_n) begin
    if (!rst_n) pass_q <= 1'b0;
    else        pass_q <= run_q & div1;
  end

  assign lane_clk = (src_clk & pass_q) | q_q;
  assign busy     = busy_q;
endmodule

// File: rtl/ckout_ctrl.sv
`timescale 1ns/1ps
module ckout_ctrl
  import ckout_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_SRC  = 16,
  parameter int unsigned LOG2_MAX = 4,
  localparam int unsigned SEL_W = $clog2(NUM_SRC),
  localparam int unsigned SH_W  = $clog2(LOG2_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic [NUM_SRC-1:0] lane_busy,
  output logic [NUM_SRC-1:0] lane_req,
  output logic [SH_W-1:0]    shift,
  output logic               pad_oe
);
  // programmed register
  logic             cfg_en_q, cfg_en_n;
  logic [DIV_W-1:0] cfg_div_q, cfg_div_n;
  logic [SEL_W-1:0] cfg_sel_q, cfg_sel_n;
  // applied setting
  logic             act_en_q, act_en_n;
  logic [DIV_W-1:0] act_div_q, act_div_n;
  logic [SEL_W-1:0] act_sel_q, act_sel_n;
  logic             req_on_q, req_on_n;
  logic [NUM_SRC-1:0] req_q, req_n;
  logic [NUM_SRC-1:0] busy_s1_q, busy_s2_q;
  seq_state_e       st_q, st_n;
  logic             pending;

  // register write path
  always_comb begin
    cfg_en_n  = cfg_en_q;
    cfg_div_n = cfg_div_q;
    cfg_sel_n = cfg_sel_q;
    if (we) begin
      cfg_en_n  = wdata[EN_BIT];
      cfg_div_n = wdata[DIV_LSB +: DIV_W];
      cfg_sel_n = wdata[SEL_LSB +: SEL_W];
    end
  end

  always_comb begin
    rdata = '0;
    rdata[EN_BIT]             = cfg_en_q;
    rdata[DIV_LSB +: DIV_W]   = cfg_div_q;
    rdata[SEL_LSB +: SEL_W]   = cfg_sel_q;
  end

  assign pending = {cfg_en_q, cfg_div_q, cfg_sel_q} != {act_en_q, act_div_q, act_sel_q};

  // switching sequencer
  always_comb begin
    st_n      = st_q;
    act_en_n  = act_en_q;
    act_div_n = act_div_q;
    act_sel_n = act_sel_q;
    req_on_n  = req_on_q;
    unique case (st_q)
      ST_HOLD: begin
        if (pending) begin
          if (act_en_q) begin
            req_on_n = 1'b0;
            st_n     = ST_DRAIN;
          end else begin
            act_en_n  = cfg_en_q;
            act_div_n = cfg_div_q;
            act_sel_n = cfg_sel_q;
            if (cfg_en_q) begin
              req_on_n = 1'b1;
              st_n     = ST_WAKE;
            end
          end
        end
      end
      ST_DRAIN: begin
        if (busy_s2_q == '0) begin
          act_en_n  = cfg_en_q;
          act_div_n = cfg_div_q;
          act_sel_n = cfg_sel_q;
          req_on_n  = cfg_en_q;
          st_n      = cfg_en_q ? ST_WAKE : ST_HOLD;
        end
      end
      ST_WAKE: begin
        if (busy_s2_q[act_sel_q]) st_n = ST_HOLD;
      end
      default: st_n = ST_HOLD;
    endcase
    for (int i = 0; i < int'(NUM_SRC); i++) begin
      req_n[i] = req_on_n && (act_sel_n == SEL_W'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_en_q  <= 1'b0;
      cfg_div_q <= '0;
      cfg_sel_q <= '0;
      act_en_q  <= 1'b0;
      act_div_q <= '0;
      act_sel_q <= '0;
      req_on_q  <= 1'b0;
      req_q     <= '0;
      busy_s1_q <= '0;
      busy_s2_q <= '0;
      st_q      <= ST_HOLD;
    end else begin
      cfg_en_q  <= cfg_en_n;
      cfg_div_q <= cfg_div_n;
      cfg_sel_q <= cfg_sel_n;
      act_en_q  <= act_en_n;
      act_div_q <= act_div_n;
      act_sel_q <= act_sel_n;
      req_on_q  <= req_on_n;
      req_q     <= req_n;
      busy_s1_q <= lane_busy;
      busy_s2_q <= busy_s1_q;
      st_q      <= st_n;
    end
  end

  // reserved codes saturate at the largest divider
  always_comb begin
    if (int'(act_div_q) > int'(LOG2_MAX)) shift = SH_W'(LOG2_MAX);
    else                                  shift = SH_W'(act_div_q);
  end

  assign lane_req = req_q;
  assign pad_oe   = act_en_q;
endmodule

// File: rtl/ckout_unit.sv
`timescale 1ns/1ps
module ckout_unit #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_SRC  = 16,
  parameter int unsigned LOG2_MAX = 4
) (
  input  logic               sys_clk,
  input  logic               sys_rst_n,
  input  logic               cfg_we,
  input  logic [DATA_W-1:0]  cfg_wdata,
  output logic [DATA_W-1:0]  cfg_rdata,
  input  logic [NUM_SRC-1:0] src_clk,
  output logic               clk_out,
  output logic               pad_oe
);
  localparam int unsigned SH_W = $clog2(LOG2_MAX + 1);

  logic               sys_rst_q;
  logic [NUM_SRC-1:0] lane_req;
  logic [NUM_SRC-1:0] lane_busy;
  logic [NUM_SRC-1:0] lane_clk;
  logic [SH_W-1:0]    shift;

  ckout_rst_sync u_sys_rst (.clk(sys_clk), .arst_n(sys_rst_n), .rst_n(sys_rst_q));

  ckout_ctrl #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC), .LOG2_MAX(LOG2_MAX)) u_ctrl (
    .clk       (sys_clk),
    .rst_n     (sys_rst_q),
    .we        (cfg_we),
    .wdata     (cfg_wdata),
    .rdata     (cfg_rdata),
    .lane_busy (lane_busy),
    .lane_req  (lane_req),
    .shift     (shift),
    .pad_oe    (pad_oe)
  );

  for (genvar g = 0; g < int'(NUM_SRC); g++) begin : g_lane
    ckout_lane #(.LOG2_MAX(LOG2_MAX)) u_lane (
      .src_clk  (src_clk[g]),
      .arst_n   (sys_rst_n),
      .req      (lane_req[g]),
      .shift    (shift),
      .lane_clk (lane_clk[g]),
      .busy     (lane_busy[g])
    );
  end

  // at most one lane is ever non-idle, so a plain OR cannot glitch
  assign clk_out = |lane_clk;
endmodule

// File: rtl/ckout_unit_chk.sv
`timescale 1ns/1ps
module ckout_unit_chk #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_SRC = 16
) (
  input logic               sys_clk,
  input logic               rst_n,
  input logic               cfg_we,
  input logic [DATA_W-1:0]  cfg_wdata,
  input logic [DATA_W-1:0]  cfg_rdata,
  input logic               pad_oe,
  input logic               clk_out,
  input logic [NUM_SRC-1:0] lane_req,
  input logic [NUM_SRC-1:0] lane_busy
);
  localparam int unsigned SEL_W = $clog2(NUM_SRC);
  localparam logic [DATA_W-1:0] LIVE = DATA_W'((1 << 9) | (7 << 6) | ((1 << SEL_W) - 1));

  assert_write_readback_R2: assert property (@(posedge sys_clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata == ($past(cfg_wdata) & LIVE));

  assert_unused_zero_R2: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (cfg_rdata & ~LIVE) == '0);

  assert_single_request_R3: assert property (@(posedge sys_clk) disable iff (!rst_n)
    $onehot0(lane_req));

  assert_no_request_when_off_R7: assert property (@(posedge sys_clk) disable iff (!rst_n)
    !pad_oe |-> lane_req == '0);

  assert_quiet_when_off_R9: assert property (@(posedge sys_clk) disable iff (!rst_n)
    !pad_oe |-> !clk_out);

  assert_single_lane_R8: assert property (@(posedge sys_clk) disable iff (!rst_n)
    $onehot0(lane_busy));
endmodule

bind ckout_unit ckout_unit_chk #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) u_chk (
  .sys_clk   (sys_clk),
  .rst_n     (sys_rst_q),
  .cfg_we    (cfg_we),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .pad_oe    (pad_oe),
  .clk_out   (clk_out),
  .lane_req  (lane_req),
  .lane_busy (lane_busy)
);

// File: tb/ckout_unit_test.sv
`timescale 1ns/1ps
module ckout_unit_test;
  localparam int NSRC = 16;

  logic            sys_clk;
  logic            sys_rst_n;
  logic            cfg_we;
  logic [31:0]     cfg_wdata;
  logic [31:0]     cfg_rdata;
  logic [NSRC-1:0] src_clk;
  logic            clk_out;
  logic            pad_oe;

  int checks = 0;
  int errors = 0;
  int rise_cnt = 0;
  real half_old = 0.0;
  real half_new = 0.0;
  real t_rise = 0.0;
  real t_fall = 0.0;
  bit  seen_rise = 0;
  bit  seen_fall = 0;

  ckout_unit uut (
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .src_clk(src_clk), .clk_out(clk_out), .pad_oe(pad_oe)
  );

  initial begin
    sys_clk = 1'b0;
    forever #4 sys_clk = ~sys_clk;
  end

  // source n: half period 5+n ns, arbitrary phase
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic c;
    initial begin
      c = 1'b0;
      #(0.37 * g + 0.1);
      forever #(5 + g) c = ~c;
    end
    assign src_clk[g] = c;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input real act, input real exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
    end
  endtask

  function automatic real half_of(input int sel, input int code);
    int k;
    k = (code > 4) ? 4 : code;
    return (5.0 + sel) * (2.0 ** k);
  endfunction

  function automatic bit near(input real a, input real b);
    return (a - b < 0.01) && (b - a < 0.01);
  endfunction

  task automatic do_write(input logic [31:0] v);
    @(negedge sys_clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge sys_clk);
    cfg_we = 1'b0;
    half_old = half_new;
    half_new = v[9] ? half_of(int'(v[3:0]), int'(v[8:6])) : 0.0;
  endtask

  // pulse monitor: R8 widths, R9 pad enable at every rising edge
  always @(posedge clk_out) begin
    real w, lim;
    t_rise = $realtime;
    rise_cnt++;
    check(pad_oe === 1'b1, "R9", "pad_oe at output rise", real'(pad_oe), 1.0);
    if (seen_fall) begin
      w = t_rise - t_fall;
      lim = (half_old > 0.0 && (half_new == 0.0 || half_old < half_new)) ? half_old : half_new;
      check(w > lim - 0.01, "R8", "low pulse width", w, lim);
    end
    seen_rise = 1;
  end

  always @(negedge clk_out) begin
    real w;
    t_fall = $realtime;
    if (seen_rise) begin
      w = t_fall - t_rise;
      check(near(w, half_old) || near(w, half_new), "R8", "high pulse width", w, half_new);
    end
    seen_fall = 1;
  end

  task automatic measure(input int sel, input int code);
    logic [31:0] v;
    real t0, t1, t2, exp_half;
    string rq;
    v = 32'h200 | (32'(code) << 6) | 32'(sel);
    do_write(v);
    rq = (code > 4) ? "R5" : "R4";
    check(cfg_rdata == v, (code > 4) ? "R5" : "R2", "readback", real'(cfg_rdata), real'(v));
    #1500;
    check(pad_oe === 1'b1, "R7", "pad_oe enabled", real'(pad_oe), 1.0);
    @(posedge clk_out); t0 = $realtime;
    @(negedge clk_out); t1 = $realtime;
    @(posedge clk_out); t2 = $realtime;
    exp_half = half_of(sel, code);
    check(near(t2 - t0, 2.0 * exp_half), rq, $sformatf("R3 period src %0d code %0d", sel, code),
          t2 - t0, 2.0 * exp_half);
    check(near(t1 - t0, exp_half), "R6", $sformatf("high time src %0d code %0d", sel, code),
          t1 - t0, exp_half);
  endtask

  initial begin
    #1200000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n0;
    cfg_we = 1'b0;
    cfg_wdata = '0;
    sys_rst_n = 1'b0;
    repeat (10) @(negedge sys_clk);
    check(cfg_rdata == 0, "R1", "rdata in reset", real'(cfg_rdata), 0.0);
    check(pad_oe === 1'b0 && clk_out === 1'b0, "R1", "outputs in reset", real'(pad_oe), 0.0);
    sys_rst_n = 1'b1;
    repeat (5) @(negedge sys_clk);
    check(cfg_rdata == 0, "R1", "rdata after reset", real'(cfg_rdata), 0.0);
    check(pad_oe === 1'b0 && clk_out === 1'b0, "R1", "outputs after reset", real'(clk_out), 0.0);

    // R2: only the live bits store
    do_write(32'hFFFF_FFFF);
    check(cfg_rdata == 32'h3CF, "R2", "all ones readback", real'(cfg_rdata), 975.0);
    do_write(32'hFFFF_FC30);
    check(cfg_rdata == 32'h0, "R2", "unused bits ignored", real'(cfg_rdata), 0.0);
    #2000;
    check(pad_oe === 1'b0, "R7", "pad_oe off", real'(pad_oe), 0.0);

    // R3/R4: the two documented control words
    measure(8, 0);
    measure(0, 4);

    // near-exhaustive sweep: every source against every code
    for (int s = 0; s < NSRC; s++) begin
      for (int c = 0; c < 8; c++) begin
        measure(s, c);
      end
    end

    // R9: disable from the slowest setting (src 15, div 16)
    measure(15, 4);
    do_write(32'h0);
    @(negedge sys_clk);
    check(pad_oe === 1'b1, "R9", "pad_oe held during drain", real'(pad_oe), 1.0);
    #1500;
    check(pad_oe === 1'b0, "R9", "pad_oe after drain", real'(pad_oe), 0.0);
    n0 = rise_cnt;
    #2000;
    check(rise_cnt == n0 && clk_out === 1'b0, "R7", "no edges when off", real'(rise_cnt - n0), 0.0);

    // R7: changing fields while off keeps the pin quiet
    do_write(32'h0000_01C5);
    n0 = rise_cnt;
    #2000;
    check(rise_cnt == n0 && pad_oe === 1'b0, "R7", "quiet with fields set", real'(rise_cnt - n0), 0.0);
    check(cfg_rdata == 32'h1C5, "R5", "reserved code stored while off", real'(cfg_rdata), 453.0);

    // re-enable after being off, then a direct switch between two enabled settings
    measure(3, 2);
    measure(12, 1);
    measure(1, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule